// File: doc/BRIEF.md
# Digital Edge/Level Waiter with Timeout

This block waits on one asynchronous digital line for a chosen condition and reports when that condition is met or when a timeout runs out. A one-cycle `start` arms the unit. At arming it captures a 3-bit condition code and a signed timeout counted in clock ticks. The line passes through a synchronizer. While the unit is busy, each cycle compares the synchronized sample with the one from the cycle before.

The result is a one-cycle `done` pulse, with `timed_out` qualifying it in the same cycle. The timeout sign selects the policy:

- A zero timeout ends the wait at once as a timeout.
- A negative timeout disables the limit.
- A positive value N allows at most N busy cycles.

Top module: `edge_level_waiter`

## Requirements
- R1: Condition codes are 0 = rising edge, 1 = falling edge, 2 = either edge, 3 = line high, 4 = line low.
- R2: The line passes through a two-stage synchronizer. A change applied before clock edge e is seen by the detector in the cycle after edge e+1. If that change satisfies the condition, `done` rises at edge e+2.
- R3: Edge conditions are met only by a transition of the synchronized line that happens after arming. A transition before arming does not count.
- R4: Level conditions are met in the first busy cycle if the synchronized line already has the requested level. `done` then appears one edge after the arming edge.
- R5: A zero timeout ends the wait at the arming edge. `done` and `timed_out` are high in the following cycle, and `busy` never rises.
- R6: A positive timeout N gives exactly N busy cycles. If the condition is not met in any of them, `done` and `timed_out` rise at the N-th edge after arming.
- R7: A negative timeout never produces `timed_out`. The unit stays busy until the condition is met.
- R8: When the condition is met in the last allowed busy cycle, the outcome is success, with `timed_out` low.
- R9: `done` lasts one cycle. `timed_out` is high only together with `done`. `busy` is high from the arming edge until the edge that raises `done`, and is low while `done` is high.
- R10: `start` is ignored while `busy` is high.
- R11: Codes 5, 6 and 7 are reserved. They end the wait at the arming edge with `timed_out` set, in the same way as R5.
- R12: While `rst_n` is low, `busy`, `done` and `timed_out` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a wait when the unit is idle |
| mode | input | 3 | Condition code (R1, R11) |
| timeout | input | TW (32) | Signed timeout in clock ticks |
| line_in | input | 1 | Asynchronous digital line |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle end-of-wait pulse |
| timed_out | output | 1 | Qualifies `done`: the wait ended by timeout |

## Verification
The assertions assume the following about the inputs:

- `mode` and `timeout` matter only in the cycle where `start` meets an idle unit.
- `line_in` is asynchronous and is observed only through the synchronizer.
- `start` may arrive at any time, including while the unit is busy.

The stimulus changes every input half a period away from the sampling edge. It holds the line steady for several cycles before each arming, so the level at arming is settled. The stimulus also deliberately pulses `start` during a wait, to exercise the busy-ignore path.

// File: rtl/waiter_pkg.sv
package waiter_pkg;
   typedef enum logic [2:0] {
      WM_RISE = 3'd0,
      WM_FALL = 3'd1,
      WM_ANY  = 3'd2,
      WM_HIGH = 3'd3,
      WM_LOW  = 3'd4
   } wait_mode_e;

   localparam int unsigned WM_LAST = 4;

   function automatic logic mode_is_valid(input logic [2:0] code);
      return code <= 3'(WM_LAST);
   endfunction
endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q[i] <= 1'b0;
            end else begin
               if (i == 0) stg_q[i] <= d_async;
               else        stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/wl_cond.sv
module wl_cond
   import waiter_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  logic [2:0] sel,
   output logic       hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp;
   end

   logic rise_w, fall_w;
   assign rise_w = smp & ~prev_q;
   assign fall_w = ~smp & prev_q;

   always_comb begin
      unique case (sel)
         3'(WM_RISE): hit = rise_w;
         3'(WM_FALL): hit = fall_w;
         3'(WM_ANY):  hit = rise_w | fall_w;
         3'(WM_HIGH): hit = smp;
         3'(WM_LOW):  hit = ~smp;
         default:     hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/wl_timer.sv
module wl_timer #(
   parameter int unsigned TW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic signed [TW-1:0] tmo,
   input  logic                 run,
   output logic                 expire
);
   localparam int unsigned CW = TW - 1;
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          inf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         inf_q <= 1'b0;
      end else if (load) begin
         cnt_q <= tmo[CW-1:0];
         inf_q <= tmo[TW-1];
      end else if (run && !inf_q && cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign expire = run && !inf_q && (cnt_q == CNT_ONE);

   // R6: a finite budget shrinks by one per busy cycle
   assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !inf_q && cnt_q > CNT_ONE) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/edge_level_waiter.sv
module edge_level_waiter
   import waiter_pkg::*;
#(
   parameter int unsigned TW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [2:0]           mode,
   input  logic signed [TW-1:0] timeout,
   input  logic                 line_in,
   output logic                 busy,
   output logic                 done,
   output logic                 timed_out
);
   generate
      if (TW < 2) begin : g_bad_tw
         $error("edge_level_waiter: TW must be at least 2");
      end
   endgenerate

   logic       smp_w, hit_w, expire_w, arm_w, now_w;
   logic       busy_q, done_q, to_q;
   logic [2:0] mode_q;

   assign arm_w = start && !busy_q;
   assign now_w = !mode_is_valid(mode) || (timeout == '0);

   wl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(line_in), .q_sync(smp_w));

   wl_cond u_cond (
      .clk(clk), .rst_n(rst_n), .smp(smp_w), .sel(mode_q), .hit(hit_w));

   wl_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(arm_w), .tmo(timeout),
      .run(busy_q), .expire(expire_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         to_q   <= 1'b0;
         mode_q <= 3'(WM_RISE);
      end else begin
         done_q <= 1'b0;
         to_q   <= 1'b0;
         if (arm_w) begin
            mode_q <= mode;
            if (now_w) begin
               done_q <= 1'b1;
               to_q   <= 1'b1;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            if (hit_w) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else if (expire_w) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               to_q   <= 1'b1;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign timed_out = to_q;

   // R5 / R11: immediate finish with timeout flag
   assert_instant_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (timeout == '0 || mode > 3'd4)) |=> (done && timed_out && !busy));
   // R8: a met condition beats the expiring budget
   assert_cond_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hit_w) |=> (done && !timed_out));
   // R9: output protocol
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_flag_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out |-> done);
   assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R10: start during a wait leaves the wait running
   assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !hit_w && !expire_w) |=> (busy && !done));
endmodule

// File: tb/edge_level_waiter_tb_top.sv
module edge_level_waiter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic signed [31:0] tmo = 32'sd0;
   logic        line = 1'b0;
   logic        busy, done, timed_out;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   edge_level_waiter dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .timeout(tmo),
      .line_in(line), .busy(busy), .done(done), .timed_out(timed_out));

   typedef struct packed {
      logic [2:0] m;
      int         t;
      logic       init;
      int         tog;
      logic       exp_to;
      int         lat;
   } vec_t;

   // tog: line flips before that edge after arming (-1 = never); lat: edge count to done
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{3'd0,  20, 1'b0,  3, 1'b0,  5},  // R1 R2 rising
      '{3'd0,  20, 1'b1,  3, 1'b1, 20},  // R1 R6 falling edge ignored by rise mode
      '{3'd1,  20, 1'b1,  4, 1'b0,  6},  // R1 falling
      '{3'd2,  20, 1'b1,  2, 1'b0,  4},  // R1 any edge
      '{3'd3,  10, 1'b1, -1, 1'b0,  1},  // R4 high already
      '{3'd4,  10, 1'b1,  5, 1'b0,  7},  // R1 low after drop
      '{3'd3,   0, 1'b1, -1, 1'b1,  0},  // R5 zero timeout
      '{3'd5,  10, 1'b0, -1, 1'b1,  0},  // R11 reserved
      '{3'd7,  10, 1'b0, -1, 1'b1,  0},  // R11 reserved
      '{3'd0,  -1, 1'b0, 30, 1'b0, 32},  // R7 infinite
      '{3'd0,   5, 1'b0,  3, 1'b0,  5},  // R8 tie
      '{3'd0,   4, 1'b0,  3, 1'b1,  4},  // R6 budget ends first
      '{3'd0,   8, 1'b1, -1, 1'b1,  8}   // R3 pre-arm rise not counted
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input string tag);
      int lat = 0;
      bit seen = 0;
      bit busy0 = 0;
      bit to_at = 0;
      bit busy_at = 0;
      @(negedge clk);
      line = v.init;
      start = 1'b0;
      repeat (4) @(negedge clk);
      mode = v.m;
      tmo = v.t;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      busy0 = busy;
      while (!seen && lat < 60) begin
         if (done) begin
            seen = 1;
            to_at = timed_out;
            busy_at = busy;
         end else begin
            if (lat + 1 == v.tog) line = ~line;
            @(posedge clk);
            lat++;
            @(negedge clk);
         end
      end
      check(seen && lat == v.lat, {tag, " latency"}, lat, v.lat);
      check(to_at == v.exp_to, {tag, " timed_out"}, int'(to_at), int'(v.exp_to));
      check(!busy_at, "R9 busy low with done", int'(busy_at), 0);
      check(busy0 == (v.lat > 0), "R9 busy after arming", int'(busy0), int'(v.lat > 0));
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !timed_out, "R12 reset state", int'({busy, done, timed_out}), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i], $sformatf("vector %0d", i));
      end

      // R10: a start during a wait (reserved code, zero timeout) must not end the wait
      begin
         int lat = 0;
         bit seen = 0;
         @(negedge clk);
         line = 1'b0;
         repeat (4) @(negedge clk);
         mode = 3'd0;
         tmo = 32'sd20;
         start = 1'b1;
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         while (!seen && lat < 60) begin
            if (done) seen = 1;
            else begin
               if (lat == 2) begin
                  start = 1'b1; mode = 3'd5; tmo = 32'sd0;
               end else begin
                  start = 1'b0;
               end
               if (lat + 1 == 6) line = 1'b1;
               @(posedge clk);
               lat++;
               @(negedge clk);
            end
         end
         check(seen && lat == 8, "R10 start ignored latency", lat, 8);
         check(!timed_out, "R10 start ignored flag", int'(timed_out), 0);
      end

      // R12: reset in the middle of an unbounded wait
      @(negedge clk);
      line = 1'b0;
      repeat (4) @(negedge clk);
      mode = 3'd3;
      tmo = -32'sd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(busy, "R7 still busy", int'(busy), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!busy && !done && !timed_out, "R12 mid-wait reset", int'({busy, done, timed_out}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !done, "R12 stays idle", int'({busy, done}), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule